// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block watches for software that has stopped making progress. It takes a free-running 64-bit system count as an input and compares that count with an absolute 64-bit deadline. When the count reaches the deadline for the first time, the block raises a warning level (`ws0_o`) that is meant to drive an interrupt. It then moves the deadline one offset interval further on. If the count reaches the new deadline while the warning is still set, the block raises a second level (`ws1_o`) that is meant to request a system reset.

Software talks to the block over a simple single-cycle read/write bus that has two frames. The control frame holds the enable and status word, the offset interval, the read-only deadline and an identification word. The refresh frame has one job: any write to it clears the warning and restarts the first interval. The offset interval is 32 bits wide in architecture version 0 and 48 bits wide in version 1. The identification word reports which version is built.

Top module: `wdt_top`

## Requirements
- R1: After reset, `ws0_o` and `ws1_o` are low, and the enable, the offset and the deadline are zero.
- R2: The control word at control address 0x00 reads with enable in bit 0, the warning in bit 1 and the reset request in bit 2. All other bits read as zero.
- R3: A control write that sets bit 0 while the block is disabled loads the deadline with the current count plus the offset. The deadline reads at 0x10 (bits 31:0) and 0x14 (bits 63:32).
- R4: While the block is enabled and the warning is clear, a count greater than or equal to the deadline sets `ws0_o` at the next clock edge. The same edge reloads the deadline with that count plus the offset.
- R5: While the block is enabled and `ws0_o` is high, a count greater than or equal to the deadline sets `ws1_o` at the next clock edge. The time from a refresh to `ws1_o` is therefore twice the offset.
- R6: A write to the refresh frame clears `ws0_o` and reloads the deadline with the count plus the offset. A refresh in the same cycle as a first-stage expiry takes priority, so `ws0_o` stays low.
- R7: A control write with bit 0 clear disables the block and clears `ws0_o` and `ws1_o`. While the block is disabled, no count value sets either output.
- R8: Once `ws1_o` is set, it stays high through refreshes and later expiries until the block is disabled or reset.
- R9: The offset low word is at 0x08. In version 1, bits 15:0 of the word at 0x0C hold offset bits 47:32, and bits 31:16 of that word read as zero. In version 0, a write to 0x0C is ignored and the word reads as zero.
- R10: The identification word at 0x1C reports the version in bits 19:16 and the implementer code in bits 10:0. All other bits read as zero.
- R11: A write to either offset word loads the deadline with the current count plus the new offset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 64 | Free-running system count |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| frame_i | input | 1 | 0 = control frame, 1 = refresh frame |
| addr_i | input | ADDR_W | Byte address within the frame |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational, zero when no control read) |
| ws0_o | output | 1 | First-stage warning level |
| ws1_o | output | 1 | Second-stage reset request level |

## Verification
The hardest case to reach is a refresh that arrives in exactly the cycle in which the count first reaches the deadline. From a free-running counter this would be a matter of luck. The bench avoids that by driving the count as a plain input: it reads back the deadline, parks the count on that exact value and issues the refresh write in the same cycle. The bench also sweeps several offsets and base counts, including one just below a 32-bit carry. For each case it steps the count one tick at a time toward both deadlines, so that every off-by-one in the two stages shows up. A second instance built as version 0 is checked for the narrower offset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] A_CTL    = 8'h00;
  localparam logic [7:0] A_OFS_LO = 8'h08;
  localparam logic [7:0] A_OFS_HI = 8'h0C;
  localparam logic [7:0] A_CMP_LO = 8'h10;
  localparam logic [7:0] A_CMP_HI = 8'h14;
  localparam logic [7:0] A_IDR    = 8'h1C;

  localparam int CTL_EN  = 0;
  localparam int CTL_WS0 = 1;
  localparam int CTL_WS1 = 2;

  typedef enum logic {FR_CTL = 1'b0, FR_REFRESH = 1'b1} frame_e;
endpackage

// File: rtl/wdt_ofs_reg.sv
module wdt_ofs_reg #(
  parameter int VERSION = 1,
  parameter int CW      = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [31:0]   wdata_i,
  output logic [CW-1:0] ofs_q_o,
  output logic [CW-1:0] ofs_d_o,
  output logic [31:0]   hi_rd_o
);
  logic [31:0] lo_q, lo_d;

  assign lo_d = wr_lo_i ? wdata_i : lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lo_q <= '0;
    else         lo_q <= lo_d;
  end

  generate
    if (VERSION >= 1) begin : g_wide
      localparam int HI_W = 16;
      logic [HI_W-1:0] hi_q, hi_d;
      assign hi_d = wr_hi_i ? wdata_i[HI_W-1:0] : hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hi_q <= '0;
        else         hi_q <= hi_d;
      end
      assign ofs_q_o = CW'({hi_q, lo_q});
      assign ofs_d_o = CW'({hi_d, lo_d});
      assign hi_rd_o = 32'(hi_q);
    end else begin : g_narrow
      logic unused_hi;
      assign unused_hi = wr_hi_i;
      assign ofs_q_o = CW'(lo_q);
      assign ofs_d_o = CW'(lo_d);
      assign hi_rd_o = '0;
    end
  endgenerate
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] ofs_d_i,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          refresh_i,
  input  logic          clr_i,
  output logic [CW-1:0] cmp_o,
  output logic          ws0_o,
  output logic          ws1_o
);
  logic [CW-1:0] cmp_q;
  logic          ws0_q, ws1_q;
  logic          hit, first_hit, second_hit;

  assign hit        = en_i && (cnt_i >= cmp_q);
  // a reload of any kind pre-empts both stages
  assign first_hit  = hit && !ws0_q && !load_i;
  assign second_hit = hit &&  ws0_q && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      ws0_q <= 1'b0;
      ws1_q <= 1'b0;
    end else begin
      if (load_i || first_hit) cmp_q <= cnt_i + ofs_d_i;

      if (clr_i || refresh_i) ws0_q <= 1'b0;
      else if (first_hit)     ws0_q <= 1'b1;

      if (clr_i)           ws1_q <= 1'b0;
      else if (second_hit) ws1_q <= 1'b1;
    end
  end

  assign cmp_o = cmp_q;
  assign ws0_o = ws0_q;
  assign ws1_o = ws1_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
  parameter int          VERSION   = 1,
  parameter logic [10:0] IMPL_CODE = 11'h2A5,
  parameter int          ADDR_W    = 8,
  parameter int          CW        = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     cnt_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              frame_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              ws0_o,
  output logic              ws1_o
);
  import wdt_pkg::*;

  localparam logic [31:0] ID_WORD = (32'(VERSION & 15) << 16) | 32'(IMPL_CODE);

  logic          ctl_sel, wr, rd;
  logic          ctl_wr, ofs_lo_wr, ofs_hi_wr, refresh;
  logic          en_q, en_rise, dis;
  logic [CW-1:0] ofs_q, ofs_d, cmp;
  logic [63:0]   cmp64;
  logic [31:0]   ofs_hi_rd;

  assign ctl_sel   = req_i && (frame_i == FR_CTL);
  assign wr        = ctl_sel && we_i;
  assign rd        = ctl_sel && !we_i;
  assign ctl_wr    = wr && (addr_i == ADDR_W'(A_CTL));
  assign ofs_lo_wr = wr && (addr_i == ADDR_W'(A_OFS_LO));
  assign ofs_hi_wr = wr && (addr_i == ADDR_W'(A_OFS_HI));
  assign refresh   = req_i && we_i && (frame_i == FR_REFRESH);
  assign en_rise   = ctl_wr &&  wdata_i[CTL_EN] && !en_q;
  assign dis       = ctl_wr && !wdata_i[CTL_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= 1'b0;
    else if (ctl_wr) en_q <= wdata_i[CTL_EN];
  end

  wdt_ofs_reg #(.VERSION(VERSION), .CW(CW)) u_ofs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_lo_i (ofs_lo_wr),
    .wr_hi_i (ofs_hi_wr),
    .wdata_i (wdata_i),
    .ofs_q_o (ofs_q),
    .ofs_d_o (ofs_d),
    .hi_rd_o (ofs_hi_rd)
  );

  wdt_stage #(.CW(CW)) u_stage (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_i),
    .ofs_d_i   (ofs_d),
    .en_i      (en_q),
    .load_i    (refresh || ofs_lo_wr || ofs_hi_wr || en_rise),
    .refresh_i (refresh),
    .clr_i     (dis),
    .cmp_o     (cmp),
    .ws0_o     (ws0_o),
    .ws1_o     (ws1_o)
  );

  assign cmp64 = 64'(cmp);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        ADDR_W'(A_CTL):    rdata_o = {29'd0, ws1_o, ws0_o, en_q};
        ADDR_W'(A_OFS_LO): rdata_o = ofs_q[31:0];
        ADDR_W'(A_OFS_HI): rdata_o = ofs_hi_rd;
        ADDR_W'(A_CMP_LO): rdata_o = cmp64[31:0];
        ADDR_W'(A_CMP_HI): rdata_o = cmp64[63:32];
        ADDR_W'(A_IDR):    rdata_o = ID_WORD;
        default:           rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_top_chk.sv
module wdt_top_chk #(
  parameter int CW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] cmp,
  input logic          en_q,
  input logic          refresh,
  input logic          dis,
  input logic          ws0_o,
  input logic          ws1_o
);
  // R4: a warning only rises after an enabled count reached the deadline
  a_r4_ws0_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws0_o) |-> $past(en_q && (cnt_i >= cmp) && !refresh));

  // R5: the reset request only rises while the warning was already set
  a_r5_ws1_after_ws0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ws1_o) |-> $past(ws0_o));

  // R6: a refresh leaves the warning clear
  a_r6_refresh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |=> !ws0_o);

  // R7: both outputs low while disabled
  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> (!ws0_o && !ws1_o));

  // R8: the reset request holds until a disable
  a_r8_ws1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws1_o && !dis) |=> ws1_o);
endmodule

bind wdt_top wdt_top_chk #(.CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cnt_i   (cnt_i),
  .cmp     (cmp),
  .en_q    (en_q),
  .refresh (refresh),
  .dis     (dis),
  .ws0_o   (ws0_o),
  .ws1_o   (ws1_o)
);

// File: tb/wdt_top_tb_top.sv
`timescale 1ns/1ps
module wdt_top_tb_top;
  localparam logic [10:0] IMPL = 11'h2A5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic        req = 1'b0, we = 1'b0, frame = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata0;
  logic        ws0, ws1, ws0_v0, ws1_v0;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  wdt_top #(.VERSION(1), .IMPL_CODE(IMPL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .req_i(req), .we_i(we),
    .frame_i(frame), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ws0_o(ws0), .ws1_o(ws1));

  wdt_top #(.VERSION(0), .IMPL_CODE(IMPL)) dut0_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .req_i(req), .we_i(we),
    .frame_i(frame), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0),
    .ws0_o(ws0_v0), .ws1_o(ws1_v0));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic fr, input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; frame = fr; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d1, output logic [31:0] d0);
    req = 1'b1; we = 1'b0; frame = 1'b0; addr = a;
    #1;
    d1 = rdata; d0 = rdata0;
    req = 1'b0;
  endtask

  task automatic rd_cmp(output logic [63:0] c);
    logic [31:0] lo, hi, x;
    rd(8'h10, lo, x);
    rd(8'h14, hi, x);
    c = {hi, lo};
  endtask

  task automatic step(input logic [63:0] c);
    cnt = c;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] a1, a0;
    logic [63:0] c, dl;
    logic [63:0] bases [3];
    bases[0] = 64'h100;
    bases[1] = 64'hFFFF_FFFD;
    bases[2] = 64'h1234_0000_0000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ws0", 64'(ws0), 0);
    chk("R1 ws1", 64'(ws1), 0);
    rd(8'h00, a1, a0); chk("R1 ctl", 64'(a1), 0);
    rd(8'h08, a1, a0); chk("R1 ofs", 64'(a1), 0);
    rd_cmp(c);         chk("R1 cmp", c, 0);

    // R10 identification
    rd(8'h1C, a1, a0);
    chk("R10 id v1", 64'(a1), 64'((32'd1 << 16) | 32'(IMPL)));
    chk("R10 id v0", 64'(a0), 64'(IMPL));

    // R9 offset widths
    wr(1'b0, 8'h08, 32'hDEAD_BEEF);
    wr(1'b0, 8'h0C, 32'hFFFF_ABCD);
    rd(8'h08, a1, a0);
    chk("R9 lo v1", 64'(a1), 64'hDEAD_BEEF);
    chk("R9 lo v0", 64'(a0), 64'hDEAD_BEEF);
    rd(8'h0C, a1, a0);
    chk("R9 hi v1", 64'(a1), 64'h0000_ABCD);
    chk("R9 hi v0", 64'(a0), 64'h0);
    wr(1'b0, 8'h0C, 32'h0);

    // sweep over offsets and base counts
    foreach (bases[b]) begin
      for (int o = 1; o <= 4; o++) begin
        wr(1'b0, 8'h00, 32'h0);
        cnt = bases[b];
        wr(1'b0, 8'h08, 32'(o));
        rd_cmp(c); chk("R11 ofs reload", c, bases[b] + 64'(o));
        cnt = bases[b] + 64'd7;
        wr(1'b0, 8'h00, 32'h1);
        dl = bases[b] + 64'd7 + 64'(o);
        rd_cmp(c); chk("R3 enable load", c, dl);
        step(dl - 64'd1); chk("R4 early", 64'(ws0), 0);
        step(dl);         chk("R4 ws0 set", 64'(ws0), 1);
        rd_cmp(c);        chk("R4 reload", c, dl + 64'(o));
        rd(8'h00, a1, a0); chk("R2 ctl ws0", 64'(a1), 64'h3);
        step(dl + 64'(o) - 64'd1); chk("R5 early", 64'(ws1), 0);
        step(dl + 64'(o));         chk("R5 ws1 set", 64'(ws1), 1);
        rd(8'h00, a1, a0); chk("R2 ctl ws1", 64'(a1), 64'h7);
        wr(1'b1, 8'h00, 32'h0);
        chk("R6 refresh ws0", 64'(ws0), 0);
        chk("R8 ws1 held", 64'(ws1), 1);
        step(dl + 64'd100); chk("R8 ws1 still", 64'(ws1), 1);
        wr(1'b0, 8'h00, 32'h0);
        chk("R7 ws0 off", 64'(ws0), 0);
        chk("R7 ws1 off", 64'(ws1), 0);
        step(64'hFFFF_FFFF_FFFF_FFF0);
        chk("R7 disabled no ws0", 64'(ws0), 0);
      end
    end

    // R6 refresh versus first expiry in one cycle
    cnt = 64'h5000;
    wr(1'b0, 8'h08, 32'h10);
    wr(1'b0, 8'h00, 32'h1);
    rd_cmp(dl);
    cnt = dl;
    wr(1'b1, 8'h00, 32'h0);
    chk("R6 race ws0", 64'(ws0), 0);
    rd_cmp(c); chk("R6 race reload", c, dl + 64'h10);
    step(dl + 64'h10); chk("R6 later expiry", 64'(ws0), 1);
    wr(1'b0, 8'h00, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule